// File: doc/BRIEF.md
# UART Receive Status and Error-Clear Unit

This block holds the receive-side state of a two-channel serial unit working as a UART. A receiver core, outside this block, signals each finished frame with a one-cycle pulse. With the pulse it gives the received byte and two results: whether the parity check failed and whether the stop bit was bad. For each channel the block keeps the last accepted byte, a buffer-full flag and three sticky error flags (parity, framing, overrun). It also keeps one enable status bit per channel. These bits are set and cleared through separate start and stop trigger registers.

Software sees the block as a small register bus. All reads return one cycle after the request. Reading a channel's data register empties its buffer. One read of the status register shows the buffer state and the type of error. Writing that status value back unchanged into the channel's clear register clears the error flags that were seen. After a framing error, software can stop the channel, restore sync with the far end and start the channel again.

Top module: `uart_rx_status`

## Requirements
- R1: After reset both enable status bits are 0, every flag is 0 and both data registers read 0.
- R2: When an enabled channel gets a frame pulse while its buffer is empty, the byte is stored. On the next cycle the buffer-full flag reads 1.
- R3: A read of a channel's data register returns the held byte and clears buffer-full. If that read falls in the same cycle as a new frame, the new byte is stored, buffer-full stays 1 and no overrun is flagged.
- R4: A frame that arrives while buffer-full is 1, with no data read in that cycle, sets the overrun flag and leaves the held byte unchanged.
- R5: An accepted frame with a bad parity result sets the parity flag. One with a bad stop bit sets the framing flag.
- R6: The status register reads bit 3 = buffer-full, bit 2 = parity, bit 1 = framing, bit 0 = overrun. All other bits read 0.
- R7: Error flags are sticky. Writing 1 to bit 2, 1 or 0 of the clear register clears the parity, framing or overrun flag. Bits written as 0, and bit 3, have no effect. A flag set in the same cycle as its clear stays set.
- R8: Writing 1 to bit n of the stop register makes enable status bit n 0. Writing 1 to bit n of the start register makes it 1. The enable state reads back at address 10, bits 1:0, and is also driven on `ch_enable`.
- R9: While a channel is disabled, its frame pulses are ignored. Its flags and held byte do not change.
- R10: The start, stop and clear registers always read back as 0.
- R11: The two channels are independent. Traffic, clears and triggers on one channel leave the other channel's flags unchanged.
- R12: Address map. Channel c uses address 4c for data, 4c+1 for status and 4c+2 for clear. Address 8 is start, 9 is stop and 10 is enable status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_done | input | NUM_CH | One-cycle frame-complete pulse per channel |
| rx_data | input | NUM_CH*DATA_W | Received byte per channel, valid with rx_done |
| rx_parity_bad | input | NUM_CH | Parity check failed for this frame |
| rx_stop_bad | input | NUM_CH | Stop bit was not high for this frame |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| ch_enable | output | NUM_CH | Enable status per channel |

## Verification
All results appear one clock edge after their stimulus. A frame pulse, a trigger write or a clear write changes the flags and enable bits at the next edge. A read captures `bus_rdata` at the edge that ends its request cycle, and its buffer-full side effect happens at that same edge. The bench drives each stimulus for one whole cycle between falling edges and samples at the following falling edge, so every check sees exactly one edge of update. The same-cycle cases are driven in a single cycle, and their effect is read back in later read cycles: a read together with a frame, and a flag set together with its clear.

// File: rtl/uart_rx_pkg.sv
// Package: shared register offsets and flag layout for the receive status unit.
// Assumes an address space of at least 4 bits and at most two channels.
package uart_rx_pkg;

    // Per-channel register offsets; channel c sits at c*CH_STRIDE
    localparam int CH_STRIDE   = 4;
    localparam int OFS_DATA    = 0;
    localparam int OFS_STAT    = 1;
    localparam int OFS_CLR     = 2;

    // Shared trigger and status addresses
    localparam int ADDR_START  = 8;
    localparam int ADDR_STOP   = 9;
    localparam int ADDR_ENSTAT = 10;

    // Number of clearable error flags
    localparam int ERR_FLAGS   = 3;

    // Status layout: bit3 full, bit2 parity, bit1 framing, bit0 overrun
    typedef struct packed {
        logic full;
        logic par;
        logic frm;
        logic ovr;
    } rx_flags_t;

endpackage

// File: rtl/uart_rx_chan.sv
// Module: one receive channel's data holding register and status flags.
// Assumes frame_done is a single-cycle pulse and data_rd/clr_wr are
// already decoded single-cycle strobes from the register decoder.
module uart_rx_chan
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 frame_done,
    input  logic [DATA_W-1:0]    frame_byte,
    input  logic                 par_bad,
    input  logic                 stop_bad,
    input  logic                 data_rd,
    input  logic                 clr_wr,
    input  logic [ERR_FLAGS-1:0] clr_mask,
    output rx_flags_t            flags,
    output logic [DATA_W-1:0]    held_byte
);

    logic accept;
    logic has_room;
    logic store;
    logic overrun_evt;
    logic clr_ovr;
    logic clr_frm;
    logic clr_par;

    // Classify the incoming frame against the buffer state
    always_comb begin
        accept      = enable && frame_done;
        has_room    = !flags.full || data_rd;
        store       = accept && has_room;
        overrun_evt = accept && !has_room;
        clr_ovr     = clr_wr && clr_mask[0];
        clr_frm     = clr_wr && clr_mask[1];
        clr_par     = clr_wr && clr_mask[2];
    end

    // Hold the byte of the last stored frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_byte <= '0;
        end else if (store) begin
            held_byte <= frame_byte;
        end
    end

    // Update buffer-full and the sticky error flags (set beats clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            if (store) begin
                flags.full <= 1'b1;
            end else if (data_rd) begin
                flags.full <= 1'b0;
            end
            flags.ovr <= overrun_evt || (flags.ovr && !clr_ovr);
            flags.frm <= (accept && stop_bad) || (flags.frm && !clr_frm);
            flags.par <= (accept && par_bad) || (flags.par && !clr_par);
        end
    end

endmodule

// File: rtl/uart_rx_ctrl.sv
// Module: per-channel enable status driven by start and stop trigger pulses.
// Assumes start_set/stop_set are single-cycle masks; stop wins on a tie.
module uart_rx_ctrl #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] start_set,
    input  logic [NUM_CH-1:0] stop_set,
    output logic [NUM_CH-1:0] enable
);

    // One enable bit per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_en
        // Apply stop before start, else hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                enable[c] <= 1'b0;
            end else if (stop_set[c]) begin
                enable[c] <= 1'b0;
            end else if (start_set[c]) begin
                enable[c] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_rx_regdec.sv
// Module: address decode of the register bus into strobes plus read mux.
// Assumes one access per cycle; trigger and clear registers read as zero.
module uart_rx_regdec
    import uart_rx_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_rd,
    input  logic                           bus_wr,
    input  logic [DATA_W-1:0]              bus_wdata,
    input  rx_flags_t [NUM_CH-1:0]         flags,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  held,
    input  logic [NUM_CH-1:0]              enable,
    output logic [NUM_CH-1:0]              data_rd,
    output logic [NUM_CH-1:0]              clr_wr,
    output logic [ERR_FLAGS-1:0]           clr_mask,
    output logic [NUM_CH-1:0]              start_set,
    output logic [NUM_CH-1:0]              stop_set,
    output logic [DATA_W-1:0]              rdata_next
);

    localparam logic [ADDR_W-1:0] A_START  = ADDR_W'(ADDR_START);
    localparam logic [ADDR_W-1:0] A_STOP   = ADDR_W'(ADDR_STOP);
    localparam logic [ADDR_W-1:0] A_ENSTAT = ADDR_W'(ADDR_ENSTAT);

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[DATA_W-1:ERR_FLAGS];

    // Per-channel strobes from the channel's address window
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(c * CH_STRIDE + OFS_DATA);
        localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(c * CH_STRIDE + OFS_CLR);
        assign data_rd[c] = bus_rd && (bus_addr == A_DATA);
        assign clr_wr[c]  = bus_wr && (bus_addr == A_CLR);
    end

    // Trigger masks and clear mask taken from write data
    always_comb begin
        clr_mask  = bus_wdata[ERR_FLAGS-1:0];
        start_set = (bus_wr && bus_addr == A_START) ? bus_wdata[NUM_CH-1:0] : '0;
        stop_set  = (bus_wr && bus_addr == A_STOP)  ? bus_wdata[NUM_CH-1:0] : '0;
    end

    // Read mux: data, status and enable state; all else reads zero
    always_comb begin
        rdata_next = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(c * CH_STRIDE + OFS_DATA)) begin
                rdata_next = held[c];
            end
            if (bus_addr == ADDR_W'(c * CH_STRIDE + OFS_STAT)) begin
                rdata_next = DATA_W'(flags[c]);
            end
        end
        if (bus_addr == A_ENSTAT) begin
            rdata_next = DATA_W'(enable);
        end
    end

endmodule

// File: rtl/uart_rx_status.sv
// Module: top of the UART receive status and error-clear unit.
// Assumes the receiver core pulses rx_done for one cycle per frame and
// that NUM_CH is at most 2 so the address map fits a 4-bit space.
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          rx_done,
    input  logic [NUM_CH*DATA_W-1:0]   rx_data,
    input  logic [NUM_CH-1:0]          rx_parity_bad,
    input  logic [NUM_CH-1:0]          rx_stop_bad,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_rd,
    input  logic                       bus_wr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [NUM_CH-1:0]          ch_enable
);

    rx_flags_t [NUM_CH-1:0]         ch_flags;
    logic [NUM_CH-1:0][DATA_W-1:0]  ch_byte;
    logic [NUM_CH-1:0]              data_rd;
    logic [NUM_CH-1:0]              clr_wr;
    logic [ERR_FLAGS-1:0]           clr_mask;
    logic [NUM_CH-1:0]              start_set;
    logic [NUM_CH-1:0]              stop_set;
    logic [DATA_W-1:0]              rdata_next;

    uart_rx_regdec #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regdec (
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .flags      (ch_flags),
        .held       (ch_byte),
        .enable     (ch_enable),
        .data_rd    (data_rd),
        .clr_wr     (clr_wr),
        .clr_mask   (clr_mask),
        .start_set  (start_set),
        .stop_set   (stop_set),
        .rdata_next (rdata_next)
    );

    uart_rx_ctrl #(
        .NUM_CH (NUM_CH)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_set (start_set),
        .stop_set  (stop_set),
        .enable    (ch_enable)
    );

    // One status/data channel per receiver
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        uart_rx_chan #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (ch_enable[c]),
            .frame_done (rx_done[c]),
            .frame_byte (rx_data[c*DATA_W +: DATA_W]),
            .par_bad    (rx_parity_bad[c]),
            .stop_bad   (rx_stop_bad[c]),
            .data_rd    (data_rd[c]),
            .clr_wr     (clr_wr[c]),
            .clr_mask   (clr_mask),
            .flags      (ch_flags[c]),
            .held_byte  (ch_byte[c])
        );
    end

    // Register read data for one-cycle read latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rdata_next;
        end
    end

endmodule

// File: rtl/uart_rx_status_chk.sv
// Module: assertion checker bound to the receive status unit.
// Assumes the same address map as the package; observes ports and the
// per-channel flag and byte state.
module uart_rx_status_chk
    import uart_rx_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          rx_done,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_rd,
    input  logic                       bus_wr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_CH-1:0]          ch_enable,
    input  rx_flags_t [NUM_CH-1:0]     flags,
    input  logic [NUM_CH-1:0][DATA_W-1:0] held
);

    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(ADDR_START);
    localparam logic [ADDR_W-1:0] A_STOP  = ADDR_W'(ADDR_STOP);

    logic unused_chk;
    assign unused_chk = ^bus_wdata;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(c * CH_STRIDE + OFS_DATA);
        localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(c * CH_STRIDE + OFS_STAT);
        localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(c * CH_STRIDE + OFS_CLR);

        p_accept_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ch_enable[c] && rx_done[c] |=> flags[c].full);

        p_overrun_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ch_enable[c] && rx_done[c] && flags[c].full && !(bus_rd && bus_addr == A_DATA)
            |=> flags[c].ovr && held[c] == $past(held[c]));

        p_status_layout_r6: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rd && bus_addr == A_STAT |=> bus_rdata == DATA_W'($past(flags[c])));

        p_parity_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            flags[c].par && !(bus_wr && bus_addr == A_CLR && bus_wdata[2]) |=> flags[c].par);

        p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
            bus_wr && bus_addr == A_STOP && bus_wdata[c] |=> !ch_enable[c]);

        p_start_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
            bus_wr && bus_addr == A_START && bus_wdata[c] |=> ch_enable[c]);

        p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_enable[c] && !bus_wr && !bus_rd |=> $stable(flags[c]) && $stable(held[c]));

        p_clear_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rd && bus_addr == A_CLR |=> bus_rdata == '0);
    end

    p_trigger_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (bus_addr == A_START || bus_addr == A_STOP) |=> bus_rdata == '0);

endmodule

bind uart_rx_status uart_rx_status_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_done   (rx_done),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ch_enable (ch_enable),
    .flags     (ch_flags),
    .held      (ch_byte)
);

// File: tb/uart_rx_status_bench.sv
// Directed bench for the receive status unit: one task per scenario.
module uart_rx_status_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 2;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [3:0] A_D0 = 4'd0, A_S0 = 4'd1, A_C0 = 4'd2;
    localparam logic [3:0] A_D1 = 4'd4, A_S1 = 4'd5, A_C1 = 4'd6;
    localparam logic [3:0] A_STA = 4'd8, A_STO = 4'd9, A_EN = 4'd10;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_CH-1:0]        rx_done = '0;
    logic [NUM_CH*DATA_W-1:0] rx_data = '0;
    logic [NUM_CH-1:0]        rx_parity_bad = '0;
    logic [NUM_CH-1:0]        rx_stop_bad = '0;
    logic [ADDR_W-1:0]        bus_addr = '0;
    logic                     bus_rd = 1'b0;
    logic                     bus_wr = 1'b0;
    logic [DATA_W-1:0]        bus_wdata = '0;
    logic [DATA_W-1:0]        bus_rdata;
    logic [NUM_CH-1:0]        ch_enable;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_status #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_uart_rx_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_done       (rx_done),
        .rx_data       (rx_data),
        .rx_parity_bad (rx_parity_bad),
        .rx_stop_bad   (rx_stop_bad),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .ch_enable     (ch_enable)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_check(string req, logic [3:0] a, logic [7:0] exp);
        logic [7:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic frame(int ch, logic [7:0] b, bit p, bit f);
        @(negedge clk);
        rx_done[ch] = 1'b1; rx_data[ch*8 +: 8] = b;
        rx_parity_bad[ch] = p; rx_stop_bad[ch] = f;
        @(negedge clk);
        rx_done = '0; rx_parity_bad = '0; rx_stop_bad = '0;
    endtask

    task automatic t_reset;
        check("R1 enable port", 8'(ch_enable), 8'h00);
        read_check("R1 enable reg", A_EN, 8'h00);
        read_check("R1 status ch0", A_S0, 8'h00);
        read_check("R1 status ch1", A_S1, 8'h00);
        read_check("R1 data ch0", A_D0, 8'h00);
        read_check("R1 data ch1", A_D1, 8'h00);
    endtask

    task automatic t_start_and_triggers;
        bus_write(A_STA, 8'h03);
        check("R8 start port", 8'(ch_enable), 8'h03);
        read_check("R8 enable reg", A_EN, 8'h03);
        read_check("R10 start reads 0", A_STA, 8'h00);
        read_check("R10 stop reads 0", A_STO, 8'h00);
        read_check("R10 clear reads 0", A_C0, 8'h00);
        bus_write(A_STA, 8'h00);
        check("R8 zero start no effect", 8'(ch_enable), 8'h03);
    endtask

    task automatic t_basic;
        frame(0, 8'hA5, 1'b0, 1'b0);
        read_check("R2 full after frame R6", A_S0, 8'h08);
        read_check("R3 data read", A_D0, 8'hA5);
        read_check("R3 full cleared", A_S0, 8'h00);
    endtask

    task automatic t_overrun;
        frame(0, 8'h11, 1'b0, 1'b0);
        frame(0, 8'h22, 1'b0, 1'b0);
        read_check("R4 overrun status", A_S0, 8'h09);
        read_check("R4 data kept", A_D0, 8'h11);
        read_check("R7 overrun sticky", A_S0, 8'h01);
        bus_write(A_C0, 8'h00);
        read_check("R7 zero clear no effect", A_S0, 8'h01);
        bus_write(A_C0, 8'h01);
        read_check("R7 overrun cleared", A_S0, 8'h00);
    endtask

    task automatic t_errors;
        logic [7:0] st;
        frame(1, 8'h5A, 1'b1, 1'b0);
        read_check("R5 parity flag", A_S1, 8'h0C);
        read_check("R5 data with parity err", A_D1, 8'h5A);
        frame(1, 8'h3C, 1'b0, 1'b1);
        bus_read(A_S1, st);
        check("R5 framing flag", st, 8'h0E);
        bus_write(A_C1, st);
        read_check("R7 writeback clears errors only", A_S1, 8'h08);
        read_check("R5 data drained", A_D1, 8'h3C);
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        rx_done[0] = 1'b1; rx_data[7:0] = 8'h77; rx_parity_bad[0] = 1'b1;
        bus_addr = A_C0; bus_wdata = 8'h04; bus_wr = 1'b1;
        @(negedge clk);
        rx_done = '0; rx_parity_bad = '0; bus_wr = 1'b0;
        read_check("R7 set beats clear", A_S0, 8'h0C);
        bus_write(A_C0, 8'h04);
        read_check("R7 parity cleared", A_S0, 8'h08);
        read_check("R2 data stored", A_D0, 8'h77);
    endtask

    task automatic t_read_with_frame;
        logic [7:0] v;
        frame(0, 8'h33, 1'b0, 1'b0);
        @(negedge clk);
        bus_addr = A_D0; bus_rd = 1'b1;
        rx_done[0] = 1'b1; rx_data[7:0] = 8'h44;
        @(negedge clk);
        bus_rd = 1'b0; rx_done = '0;
        v = bus_rdata;
        check("R3 same-cycle read old byte", v, 8'h33);
        read_check("R3 same-cycle no overrun", A_S0, 8'h08);
        read_check("R3 same-cycle new byte", A_D0, 8'h44);
    endtask

    task automatic t_stop_and_independence;
        bus_write(A_STO, 8'h01);
        check("R8 stop port", 8'(ch_enable), 8'h02);
        read_check("R8 stop reg", A_EN, 8'h02);
        frame(0, 8'h55, 1'b1, 1'b1);
        read_check("R9 disabled flags", A_S0, 8'h00);
        read_check("R9 disabled data", A_D0, 8'h44);
        frame(1, 8'h66, 1'b0, 1'b0);
        frame(1, 8'h67, 1'b0, 1'b1);
        read_check("R11 ch1 overrun+framing", A_S1, 8'h0B);
        read_check("R11 ch0 untouched", A_S0, 8'h00);
        bus_write(A_C0, 8'h07);
        read_check("R11 ch0 clear leaves ch1", A_S1, 8'h0B);
        read_check("R11 ch1 data", A_D1, 8'h66);
        bus_write(A_C1, 8'h03);
        read_check("R7 ch1 cleared", A_S1, 8'h00);
        bus_write(A_STA, 8'h01);
        read_check("R8 restart", A_EN, 8'h03);
        frame(0, 8'h99, 1'b0, 1'b0);
        read_check("R12 ch0 data after restart", A_D0, 8'h99);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_start_and_triggers();
        t_basic();
        t_overrun();
        t_errors();
        t_set_wins();
        t_read_with_frame();
        t_stop_and_independence();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule